// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This block sits between a processor data port and a 32-bit word bus that leads to memory and peripheral registers. It watches each processor request for an address inside one of two alias windows. A word in an alias window stands for exactly one bit of a word in the matching real region. One region covers on-chip RAM and the other covers peripheral registers. An alias read is sent to the bus as a plain read of the real word, and the chosen bit is returned in bit 0 of an otherwise zero result. An alias write becomes a locked read-modify-write pair on the bus. Only the target bit changes, and it takes the value of bit 0 of the write data.

All other requests pass through one for one: the same address, direction and data, and read data comes back unchanged. A qualifier input marks whether the request comes from the processor. Requests from any other master are never translated, even when they hit an alias window.

Both sides use a request/acknowledge handshake. A requester holds its request and its fields until acknowledge is high for one cycle. On the processor side, acknowledge and read data are taken from the bus acknowledge of the final bus transaction.

Top module: `bitband_bridge`

## Requirements
- R1: While reset is asserted and right after it, `mem_req_o`, `mem_lock_o` and `cpu_ack_o` are all low.
- R2: A processor request (`from_cpu_i`=1) is an alias access when address bits [31:25] are 0x11 (real region base 0x2000_0000) or 0x21 (real region base 0x4000_0000). Its target word is base + (address bits [24:7]) × 4. Its target bit is address bits [6:2]. Address bits [1:0] are ignored.
- R3: An alias read makes exactly one bus read of the target word. It returns 0x0000_0000 or 0x0000_0001, equal to the target bit.
- R4: An alias write makes a bus read of the target word and then a bus write to the same address. The written word equals the word read, with the target bit replaced by write-data bit 0. Write-data bits [31:1] have no effect.
- R5: Both transactions of an alias write carry `mem_lock_o`=1. The write request follows the read acknowledge in the very next cycle, with no idle bus cycle between the two.
- R6: Each processor request gets exactly one `cpu_ack_o` pulse. For an alias write, the pulse comes in the cycle that the bus write is acknowledged.
- R7: A non-alias request makes exactly one unlocked bus transaction with the same address, direction and write data. Read data is returned unchanged.
- R8: A request with `from_cpu_i`=0 is forwarded untranslated, even when its address falls in an alias window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Request, held until acknowledge |
| from_cpu_i | input | 1 | 1 = request comes from the processor and may be translated |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 32 | Byte address |
| cpu_wdata_i | input | 32 | Write data |
| cpu_ack_o | output | 1 | Request complete, one cycle |
| cpu_rdata_o | output | 32 | Read data, valid with acknowledge |
| mem_req_o | output | 1 | Bus request, held until bus acknowledge |
| mem_we_o | output | 1 | Bus write enable |
| mem_lock_o | output | 1 | Bus held for an indivisible read-modify-write |
| mem_addr_o | output | 32 | Bus word address |
| mem_wdata_o | output | 32 | Bus write data |
| mem_ack_i | input | 1 | Bus transaction complete |
| mem_rdata_i | input | 32 | Bus read data, valid with bus acknowledge |

## Verification
Seeded random operations are mixed across five kinds: alias reads and alias writes in both regions, plain reads and plain writes, and alias-window requests from a non-processor master. The bus model uses random latency. Comparing the bus transactions seen for each kind tells translation apart from pass-through, and a correct target word apart from a wrong bit or region offset. Directed cases cover bit 0 and bit 31, the last modelled word, and nonzero address bits [1:0]. They also include write data whose bit 0 disagrees with its upper bits, which separates an honest single-bit merge from a merge that leaks other data bits. A closing sweep of the whole memory image against the bench's shadow copy catches any stray write.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned BIT_W     = $clog2(DATA_W);
  localparam int unsigned N_REGIONS = 2;

  // index 0: RAM region, index 1: peripheral region
  localparam logic [N_REGIONS-1:0][ADDR_W-1:0] BB_BASE    = {32'h4000_0000, 32'h2000_0000};
  localparam logic [N_REGIONS-1:0][ADDR_W-1:0] ALIAS_BASE = {32'h4200_0000, 32'h2200_0000};

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS,
    ST_BIT_RD,
    ST_RMW_RD,
    ST_RMW_WR
  } bb_state_e;
endpackage

// File: rtl/bb_decode.sv
module bb_decode
  import bb_pkg::*;
#(
  parameter int unsigned SPAN_LOG2 = 20
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              xlate_en_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic [BIT_W-1:0]  bit_pos_o
);
  localparam int unsigned WIN_LOG2 = SPAN_LOG2 + BIT_W;
  localparam int unsigned LSB_W    = BIT_W + 2;

  logic [N_REGIONS-1:0] match;
  logic [ADDR_W-1:0]    word_off;

  assign word_off = ADDR_W'(addr_i[WIN_LOG2-1:LSB_W]) << 2;

  for (genvar k = 0; k < N_REGIONS; k++) begin : g_region
    assign match[k] = (addr_i[ADDR_W-1:WIN_LOG2] == ALIAS_BASE[k][ADDR_W-1:WIN_LOG2]);
  end

  always_comb begin
    hit_o      = 1'b0;
    tgt_addr_o = '0;
    for (int k = 0; k < N_REGIONS; k++) begin
      if (match[k]) begin
        hit_o      = xlate_en_i;
        tgt_addr_o = BB_BASE[k] + word_off;
      end
    end
  end

  assign bit_pos_o = addr_i[LSB_W-1:2];
endmodule

// File: rtl/bb_merge.sv
module bb_merge
  import bb_pkg::*;
(
  input  logic [DATA_W-1:0] word_i,
  input  logic [BIT_W-1:0]  bit_pos_i,
  input  logic              val_i,
  output logic [DATA_W-1:0] word_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign word_o[b] = (bit_pos_i == BIT_W'(b)) ? val_i : word_i[b];
  end
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int unsigned SPAN_LOG2 = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              from_cpu_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ack_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_lock_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  bb_state_e         state_q;
  logic              we_q, setv_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rd_word_q, merged;
  logic [BIT_W-1:0]  bit_q;
  logic              dec_hit;
  logic [ADDR_W-1:0] dec_tgt;
  logic [BIT_W-1:0]  dec_bit;

  bb_decode #(.SPAN_LOG2(SPAN_LOG2)) i_decode (
    .addr_i    (cpu_addr_i),
    .xlate_en_i(from_cpu_i),
    .hit_o     (dec_hit),
    .tgt_addr_o(dec_tgt),
    .bit_pos_o (dec_bit)
  );

  bb_merge i_merge (
    .word_i   (mem_rdata_i),
    .bit_pos_i(bit_q),
    .val_i    (setv_q),
    .word_o   (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      we_q      <= 1'b0;
      setv_q    <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rd_word_q <= '0;
      bit_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cpu_req_i) begin
          we_q    <= cpu_we_i;
          bit_q   <= dec_bit;
          setv_q  <= cpu_wdata_i[0];
          wdata_q <= cpu_wdata_i;
          if (dec_hit) begin
            addr_q  <= dec_tgt;
            state_q <= cpu_we_i ? ST_RMW_RD : ST_BIT_RD;
          end else begin
            addr_q  <= cpu_addr_i;
            state_q <= ST_PASS;
          end
        end
        ST_PASS, ST_BIT_RD, ST_RMW_WR: if (mem_ack_i) state_q <= ST_IDLE;
        ST_RMW_RD: if (mem_ack_i) begin
          wdata_q   <= merged;
          rd_word_q <= mem_rdata_i;
          state_q   <= ST_RMW_WR;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (state_q != ST_IDLE);
  assign mem_we_o    = ((state_q == ST_PASS) && we_q) || (state_q == ST_RMW_WR);
  assign mem_lock_o  = (state_q == ST_RMW_RD) || (state_q == ST_RMW_WR);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign cpu_ack_o   = mem_ack_i &&
                       ((state_q == ST_PASS) || (state_q == ST_BIT_RD) || (state_q == ST_RMW_WR));

  always_comb begin
    cpu_rdata_o = '0;
    if (state_q == ST_PASS) cpu_rdata_o = mem_rdata_i;
    else if (state_q == ST_BIT_RD) cpu_rdata_o = DATA_W'(mem_rdata_i[bit_q]);
  end

  function automatic logic in_bb_region(input logic [ADDR_W-1:0] a);
    logic r;
    r = 1'b0;
    for (int k = 0; k < N_REGIONS; k++)
      if (a[ADDR_W-1:SPAN_LOG2] == BB_BASE[k][ADDR_W-1:SPAN_LOG2]) r = 1'b1;
    return r;
  endfunction

  a_r2_target_in_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_BIT_RD) || mem_lock_o) |-> (in_bb_region(mem_addr_o) && (mem_addr_o[1:0] == 2'b00)));

  a_r4_one_bit_changed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RMW_WR) |-> ($countones(mem_wdata_o ^ rd_word_q) <= 1));

  a_r5_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_lock_o && mem_ack_i && !mem_we_o) |=> (mem_req_o && mem_we_o && mem_lock_o && $stable(mem_addr_o)));

  a_r5_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  a_r6_single_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_o |=> !cpu_ack_o);

  a_r3_bit_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ack_o && !mem_we_o && (state_q == ST_BIT_RD)) |-> (cpu_rdata_o[DATA_W-1:1] == '0));
endmodule

// File: tb/test_bitband_bridge.sv
module test_bitband_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, from_cpu = 1'b1, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic        cpu_ack;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we, mem_lock, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  bitband_bridge i_bitband_bridge (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(req), .from_cpu_i(from_cpu), .cpu_we_i(we),
    .cpu_addr_i(addr), .cpu_wdata_i(wdata), .cpu_ack_o(cpu_ack), .cpu_rdata_o(cpu_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_lock_o(mem_lock), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  int checks = 0, fails = 0;
  logic [31:0] mem     [4][64];
  logic [31:0] ref_mem [4][64];

  function automatic int bank_of(input logic [31:0] a);
    if (a[25]) return 3;
    if (a[31:28] == 4'h2) return 0;
    if (a[31:28] == 4'h4) return 1;
    return 2;
  endfunction

  assign mem_rdata = mem[bank_of(mem_addr)][mem_addr[7:2]];

  int unsigned wait_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack  <= 1'b0;
      wait_cnt <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
      if (mem_we) mem[bank_of(mem_addr)][mem_addr[7:2]] <= mem_wdata;
    end else if (mem_req) begin
      if (wait_cnt == 0) begin
        mem_ack  <= 1'b1;
        wait_cnt <= $urandom % 3;
      end else wait_cnt <= wait_cnt - 1;
    end
  end

  // bus monitor
  int          tx_n, ack_cnt, ack_at, gap_bad;
  logic        rd_pending;
  logic        tx_we [4];
  logic        tx_lock [4];
  logic [31:0] tx_addr [4];
  logic [31:0] tx_wdata [4];
  always @(negedge clk) if (rst_n) begin
    if (rd_pending && !(mem_req && mem_lock && mem_we)) gap_bad++;
    rd_pending = mem_req && mem_ack && mem_lock && !mem_we;
    if (mem_req && mem_ack) begin
      if (tx_n < 4) begin
        tx_we[tx_n] = mem_we; tx_lock[tx_n] = mem_lock;
        tx_addr[tx_n] = mem_addr; tx_wdata[tx_n] = mem_wdata;
      end
      tx_n++;
    end
    if (cpu_ack) begin
      ack_cnt++;
      ack_at = tx_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [31:0] op_rdata;
  bit          op_timeout;

  task automatic run_op(input logic c, input logic w, input logic [31:0] a, input logic [31:0] d);
    int guard;
    @(negedge clk);
    tx_n = 0; ack_cnt = 0; gap_bad = 0; rd_pending = 1'b0;
    from_cpu = c; we = w; addr = a; wdata = d; req = 1'b1;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!cpu_ack && guard < 64);
    op_rdata   = cpu_rdata;
    op_timeout = (guard >= 64);
    @(posedge clk);
    #1 req = 1'b0;
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic run_and_check(input logic c, input logic w, input logic [31:0] a, input logic [31:0] d);
    logic        is_alias, old_bit;
    logic [31:0] tgt, old_w, new_w;
    int          bp, tb;
    is_alias = c && (a[31:25] == 7'h11 || a[31:25] == 7'h21);
    tgt = ((a[31:25] == 7'h11) ? 32'h2000_0000 : 32'h4000_0000) + (32'(a[24:7]) << 2);
    bp  = int'(a[6:2]);
    run_op(c, w, a, d);
    chk(ack_cnt == 1 && !op_timeout, "R6 one ack per request", ack_cnt, 1);
    if (is_alias && !w) begin
      tb = bank_of(tgt);
      old_bit = ref_mem[tb][tgt[7:2]][bp];
      chk(op_rdata == {31'b0, old_bit}, "R3 alias read value", op_rdata, {31'b0, old_bit});
      chk(tx_n == 1 && !tx_we[0] && tx_addr[0] == tgt, "R2 alias read target", tx_addr[0], tgt);
    end else if (is_alias) begin
      tb = bank_of(tgt);
      old_w = ref_mem[tb][tgt[7:2]];
      new_w = old_w;
      new_w[bp] = d[0];
      chk(tx_n == 2, "R4 rmw transaction count", tx_n, 2);
      chk(!tx_we[0] && tx_we[1] && tx_addr[0] == tgt && tx_addr[1] == tgt, "R2 rmw target", tx_addr[1], tgt);
      chk(tx_wdata[1] == new_w, "R4 merged word", tx_wdata[1], new_w);
      chk(tx_lock[0] && tx_lock[1] && gap_bad == 0, "R5 locked back-to-back", gap_bad, 0);
      chk(ack_at == 2, "R6 ack with write", ack_at, 2);
      ref_mem[tb][tgt[7:2]] = new_w;
    end else begin
      tb = bank_of(a);
      chk(tx_n == 1 && tx_addr[0] == a && tx_we[0] == w && !tx_lock[0],
          c ? "R7 pass address" : "R8 untranslated address", tx_addr[0], a);
      if (w) begin
        chk(tx_wdata[0] == d, c ? "R7 pass write data" : "R8 untranslated data", tx_wdata[0], d);
        ref_mem[tb][a[7:2]] = d;
      end else begin
        chk(op_rdata == ref_mem[tb][a[7:2]], c ? "R7 pass read data" : "R8 read data",
            op_rdata, ref_mem[tb][a[7:2]]);
      end
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  function automatic logic [31:0] alias_addr(input int r, input int word, input int bitn, input int lo);
    return (r != 0 ? 32'h4200_0000 : 32'h2200_0000) + 32'(word * 128 + bitn * 4 + lo);
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 64; i++) begin
        mem[b][i] = $urandom;
        ref_mem[b][i] = mem[b][i];
      end
    tx_n = 0; ack_cnt = 0; ack_at = 0; gap_bad = 0; rd_pending = 1'b0;
    repeat (3) @(negedge clk);
    chk(!mem_req && !mem_lock && !cpu_ack, "R1 idle in reset", {29'b0, mem_req, mem_lock, cpu_ack}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req && !mem_lock && !cpu_ack, "R1 idle after reset", {29'b0, mem_req, mem_lock, cpu_ack}, 0);

    // directed corners
    run_and_check(1, 0, alias_addr(0, 0, 0, 0), 0);                 // R3 bit 0
    run_and_check(1, 0, alias_addr(1, 63, 31, 0), 0);               // R3 bit 31, last word
    run_and_check(1, 1, alias_addr(0, 5, 31, 0), 32'h0000_0001);    // R4 set top bit
    run_and_check(1, 1, alias_addr(0, 5, 31, 0), 32'hFFFF_FFFE);    // R4 clear, upper bits ignored
    run_and_check(1, 1, alias_addr(1, 7, 0, 0), 32'h0000_0001);     // R4 peripheral region
    run_and_check(1, 0, alias_addr(0, 5, 31, 3), 0);                // R2 low bits ignored
    run_and_check(1, 1, alias_addr(1, 9, 13, 2), 32'h8000_0001);    // R2 R4
    run_and_check(0, 1, alias_addr(0, 3, 4, 0), 32'hA5A5_5A5A);     // R8 write untranslated
    run_and_check(0, 0, alias_addr(0, 3, 4, 0), 0);                 // R8 read untranslated
    run_and_check(1, 1, 32'h6000_0010, 32'h1234_5678);              // R7
    run_and_check(1, 0, 32'h6000_0010, 0);                          // R7

    for (int n = 0; n < 400; n++) begin
      int kind, r, word, bitn;
      logic [31:0] pa, d;
      kind = int'($urandom % 5);
      r    = int'($urandom % 2);
      word = int'($urandom % 64);
      bitn = int'($urandom % 32);
      d    = $urandom;
      case (kind)
        0: run_and_check(1, 0, alias_addr(r, word, bitn, int'($urandom % 4)), d);
        1: run_and_check(1, 1, alias_addr(r, word, bitn, int'($urandom % 4)), d);
        2, 3: begin
          pa = (r == 0 ? 32'h2000_0000 : 32'h4000_0000) + 32'(word * 4);
          if ($urandom % 3 == 0) pa = 32'h6000_0000 + 32'(word * 4);
          run_and_check(1, kind == 3, pa, d);
        end
        default: run_and_check(0, $urandom % 2 == 1, alias_addr(r, word, bitn, 0), d);
      endcase
    end

    for (int b = 0; b < 4; b++) begin
      int mism = 0;
      for (int i = 0; i < 64; i++) if (mem[b][i] !== ref_mem[b][i]) mism++;
      chk(mism == 0, "R4 R7 memory image", mism, 0);
    end
    finish_run();
  end
endmodule